// File: doc/BRIEF.md
# JTAG Debug Register Access Port

This block is the target-side slave of a JTAG test access port. It follows the sixteen-state TAP controller and decodes a 5-bit instruction register. Through the port a debugger reaches an internal bank of 32-bit debug registers, an 8-bit power control register, an 8-bit sticky power status register, a 32-bit identification word and a 1-bit bypass path.

Debug registers are reached in two data scans under the register-select instruction. The first scan is 8 bits wide and carries the register number and a write flag. The second scan is 32 bits wide. On a read, it returns the selected register. On a write, it hands the shifted value to the register bus. The debug logic sits behind a plain parallel bus made of address, write data, read data, a write strobe and a read strobe. All bits shift least significant first. TDO changes on the falling edge of TCK.

Top module: `dbg_tap_port`

## Requirements
- R1: Holding TMS high for five TCK rising edges puts the controller in Test-Logic-Reset. A low `trst_n` does the same. Test-Logic-Reset loads the identification opcode 0x1E into the instruction register.
- R2: The instruction register is 5 bits wide and shifts LSB first. Capture-IR loads the pattern 0b00001, so that pattern is the first thing shifted out of TDO.
- R3: Opcode 0x1F selects a 1-bit bypass register that captures 0. Any opcode not listed in R4 to R7 also behaves as bypass. An N-bit scan through bypass returns the input delayed by one bit, with a 0 first.
- R4: Opcode 0x1E selects a 32-bit register. Capture-DR loads it with the `ID_CODE` parameter.
- R5: Opcode 0x08 selects an 8-bit power control register. Capture-DR loads its current value and Update-DR stores the shifted value. That value drives `pwr_ctl`, which resets to 0.
- R6: Opcode 0x09 selects an 8-bit power status register. A 1 on any bit of `pwr_event` sets the matching status bit. Capture-DR loads the status. At Update-DR, every bit that was shifted in as 1 clears the matching status bit. When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: Opcode 0x1C selects register access. The first DR scan after the instruction is loaded is 8 bits wide. Bits [7:1] hold the register number, which appears on `reg_addr`. Bit 0 is the write flag: 1 for a write, 0 for a read. The next DR scan is 32 bits wide, and after it the access returns to the address phase.
- R8: On a read, `reg_rd` is high for exactly one TCK cycle, during the data-phase Capture-DR. In that cycle `reg_rdata` is loaded and then shifted out LSB first. No write strobe is produced.
- R9: On a write, `reg_wr` is high for exactly one TCK cycle, during the data-phase Update-DR. In that cycle `reg_wdata` carries the 32 bits shifted in. A read never asserts `reg_wr`.
- R10: Loading any instruction, or passing through Test-Logic-Reset, returns register access to the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| pwr_event | input | PWR_W | Status set pulses, synchronous to tck |
| pwr_ctl | output | PWR_W | Power control register value |
| reg_addr | output | ASCAN_W-1 | Debug register number |
| reg_wdata | output | DATA_W | Debug register write data |
| reg_rdata | input | DATA_W | Debug register read data, valid in the cycle `reg_rd` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |

## Verification
Two things can hit the power status register in the same TCK cycle: a set event on `pwr_event` and the Update-DR clear mask of a status scan. The bench raises the event only during the Update-DR cycle of a scan whose mask clears that same bit. A second status scan must then still read the bit as set, and a third scan with the mask alone must clear it. The register-access phase flag is a second such case. Reloading the instruction in the middle of an access must drop the pending write flag, so that the next 8-bit scan is taken as an address and causes no write strobe.

// File: rtl/dtap_pkg.sv
`timescale 1ns/1ps
package dtap_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_st_e;

   localparam logic [4:0] OP_PWR_CTL  = 5'h08;
   localparam logic [4:0] OP_PWR_STAT = 5'h09;
   localparam logic [4:0] OP_REG_SEL  = 5'h1C;
   localparam logic [4:0] OP_IDCODE   = 5'h1E;
   localparam logic [4:0] OP_BYPASS   = 5'h1F;
   localparam logic [4:0] IR_CAPTURE  = 5'b00001;

endpackage

// File: rtl/dtap_fsm.sv
`timescale 1ns/1ps
module dtap_fsm
   import dtap_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e st
);

   tap_st_e nxt;

   always_comb begin
      nxt = st;
      case (st)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= ST_TLR;
      else         st <= nxt;
   end

endmodule

// File: rtl/dtap_ir.sv
`timescale 1ns/1ps
module dtap_ir
   import dtap_pkg::*;
#(
   parameter int IR_W = 5
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_st_e         st,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_tdo
);

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= '0;
         ir_q  <= IR_W'(OP_IDCODE);
      end else begin
         case (st)
            ST_TLR:    ir_q  <= IR_W'(OP_IDCODE);
            ST_CAP_IR: ir_sh <= IR_W'(IR_CAPTURE);
            ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            ST_UPD_IR: ir_q  <= ir_sh;
            default: ;
         endcase
      end
   end

   assign ir_tdo = ir_sh[0];

endmodule

// File: rtl/dtap_dr.sv
`timescale 1ns/1ps
module dtap_dr
   import dtap_pkg::*;
#(
   parameter int          IR_W    = 5,
   parameter int          DATA_W  = 32,
   parameter int          ASCAN_W = 8,
   parameter int          PWR_W   = 8,
   parameter logic [31:0] ID_CODE = 32'h1234_5001
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tdi,
   input  tap_st_e            st,
   input  logic [IR_W-1:0]    ir_q,
   input  logic [PWR_W-1:0]   pwr_event,
   input  logic [DATA_W-1:0]  reg_rdata,
   output logic [PWR_W-1:0]   pwr_ctl,
   output logic [PWR_W-1:0]   pwr_stat,
   output logic [ASCAN_W-2:0] reg_addr,
   output logic [DATA_W-1:0]  reg_wdata,
   output logic               reg_wr,
   output logic               reg_rd,
   output logic               phase,
   output logic               dr_tdo
);

   localparam int ID_W  = 32;
   localparam int SH_W  = (DATA_W > ID_W) ? DATA_W : ID_W;
   localparam int LEN_W = $clog2(SH_W + 1);

   logic            is_pc, is_ps, is_rs, is_id;
   logic            wflag;
   logic [SH_W-1:0] sh, sh_shift, cap_val;
   logic [LEN_W-1:0] len;
   logic [PWR_W-1:0] ps_clr;

   assign is_pc = (ir_q == IR_W'(OP_PWR_CTL));
   assign is_ps = (ir_q == IR_W'(OP_PWR_STAT));
   assign is_rs = (ir_q == IR_W'(OP_REG_SEL));
   assign is_id = (ir_q == IR_W'(OP_IDCODE));

   // scan length of the selected data register
   always_comb begin
      if (is_rs)              len = phase ? LEN_W'(DATA_W) : LEN_W'(ASCAN_W);
      else if (is_pc || is_ps) len = LEN_W'(PWR_W);
      else if (is_id)         len = LEN_W'(ID_W);
      else                    len = LEN_W'(1);
   end

   always_comb begin
      sh_shift = {1'b0, sh[SH_W-1:1]};
      sh_shift[int'(len) - 1] = tdi;
   end

   always_comb begin
      cap_val = '0;
      if (is_pc)                      cap_val[PWR_W-1:0]  = pwr_ctl;
      else if (is_ps)                 cap_val[PWR_W-1:0]  = pwr_stat;
      else if (is_rs && phase && !wflag) cap_val[DATA_W-1:0] = reg_rdata;
      else if (is_id)                 cap_val[ID_W-1:0]   = ID_CODE;
   end

   assign ps_clr = (st == ST_UPD_DR && is_ps) ? sh[PWR_W-1:0] : '0;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh       <= '0;
         pwr_ctl  <= '0;
         pwr_stat <= '0;
         reg_addr <= '0;
         wflag    <= 1'b0;
         phase    <= 1'b0;
      end else begin
         pwr_stat <= (pwr_stat & ~ps_clr) | pwr_event;
         case (st)
            ST_CAP_DR: sh <= cap_val;
            ST_SH_DR:  sh <= sh_shift;
            ST_UPD_DR: begin
               if (is_pc) pwr_ctl <= sh[PWR_W-1:0];
               if (is_rs) begin
                  phase <= !phase;
                  if (!phase) begin
                     reg_addr <= sh[ASCAN_W-1:1];
                     wflag    <= sh[0];
                  end
               end
            end
            ST_TLR, ST_UPD_IR: phase <= 1'b0;
            default: ;
         endcase
      end
   end

   assign reg_rd    = (st == ST_CAP_DR) && is_rs && phase && !wflag;
   assign reg_wr    = (st == ST_UPD_DR) && is_rs && phase && wflag;
   assign reg_wdata = sh[DATA_W-1:0];
   assign dr_tdo    = sh[0];

endmodule

// File: rtl/dbg_tap_port.sv
`timescale 1ns/1ps
module dbg_tap_port
   import dtap_pkg::*;
#(
   parameter int          IR_W        = 5,
   parameter int          DATA_W      = 32,
   parameter int          ASCAN_W     = 8,
   parameter int          PWR_W       = 8,
   parameter logic [31:0] ID_CODE     = 32'h1234_5001,
   parameter bit          TDO_ON_FALL = 1'b1
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   input  logic [PWR_W-1:0]   pwr_event,
   output logic [PWR_W-1:0]   pwr_ctl,
   output logic [ASCAN_W-2:0] reg_addr,
   output logic [DATA_W-1:0]  reg_wdata,
   input  logic [DATA_W-1:0]  reg_rdata,
   output logic               reg_wr,
   output logic               reg_rd
);

   if (IR_W < 5)          $error("IR_W must hold the 5-bit opcodes");
   if (ID_CODE[0] != 1'b1) $error("ID_CODE bit 0 must be 1");
   if (ASCAN_W < 2)       $error("ASCAN_W needs a write flag and an address bit");
   if (DATA_W < ASCAN_W || DATA_W < PWR_W) $error("DATA_W too narrow");

   tap_st_e         st;
   logic [IR_W-1:0] ir_q;
   logic            ir_tdo, dr_tdo, tdo_src, phase;
   logic [PWR_W-1:0] pwr_stat;

   dtap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

   dtap_ir #(.IR_W(IR_W)) u_ir (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .ir_q(ir_q), .ir_tdo(ir_tdo)
   );

   dtap_dr #(
      .IR_W(IR_W), .DATA_W(DATA_W), .ASCAN_W(ASCAN_W), .PWR_W(PWR_W), .ID_CODE(ID_CODE)
   ) u_dr (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .ir_q(ir_q),
      .pwr_event(pwr_event), .reg_rdata(reg_rdata), .pwr_ctl(pwr_ctl),
      .pwr_stat(pwr_stat), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .phase(phase), .dr_tdo(dr_tdo)
   );

   assign tdo_src = (st == ST_SH_DR) ? dr_tdo : (st == ST_SH_IR) ? ir_tdo : 1'b0;

   if (TDO_ON_FALL) begin : g_tdo_fall
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) tdo <= 1'b0;
         else         tdo <= tdo_src;
      end
   end else begin : g_tdo_comb
      assign tdo = tdo_src;
   end

endmodule

// File: rtl/dtap_chk.sv
`timescale 1ns/1ps
module dtap_chk
   import dtap_pkg::*;
#(
   parameter int IR_W  = 5,
   parameter int PWR_W = 8,
   parameter int AW    = 7
) (
   input logic             tck,
   input logic             trst_n,
   input logic             tms,
   input tap_st_e          st,
   input logic [IR_W-1:0]  ir_q,
   input logic             phase,
   input logic [PWR_W-1:0] pwr_stat,
   input logic [PWR_W-1:0] pwr_event,
   input logic [AW-1:0]    reg_addr,
   input logic             reg_wr,
   input logic             reg_rd
);

   // R1
   tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR && tms) |=> (st == ST_TLR));

   // R1
   tlr_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR) |=> (ir_q == IR_W'(OP_IDCODE)));

   // R6
   ps_event_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (|pwr_event) |=> ((pwr_stat & $past(pwr_event)) == $past(pwr_event)));

   // R7
   addr_phase_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_UPD_DR && ir_q == IR_W'(OP_REG_SEL) && !phase) |=> phase);

   // R8
   rd_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
      reg_rd |=> (!reg_rd && $stable(reg_addr)));

   // R9
   wr_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
      reg_wr |=> !reg_wr);

   // R10
   phase_rst_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_UPD_IR || st == ST_TLR) |=> !phase);

endmodule

bind dbg_tap_port dtap_chk #(.IR_W(IR_W), .PWR_W(PWR_W), .AW(ASCAN_W-1)) u_chk (
   .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_q(ir_q), .phase(phase),
   .pwr_stat(pwr_stat), .pwr_event(pwr_event), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/tb_dbg_tap_port.sv
`timescale 1ns/1ps
module tb_dbg_tap_port;

   localparam int          IR_W = 5;
   localparam logic [31:0] IDV  = 32'h1234_5001;

   typedef struct packed {
      logic        wr;
      logic [6:0]  a;
      logic [31:0] d;
   } vec_t;

   localparam vec_t VT [8] = '{
      '{1'b1, 7'h05, 32'hDEAD_BEEF},
      '{1'b1, 7'h7F, 32'h1234_5678},
      '{1'b1, 7'h00, 32'hA5A5_5A5A},
      '{1'b0, 7'h05, 32'hDEAD_BEEF},
      '{1'b0, 7'h7F, 32'h1234_5678},
      '{1'b1, 7'h05, 32'h0F0F_00FF},
      '{1'b0, 7'h05, 32'h0F0F_00FF},
      '{1'b0, 7'h00, 32'hA5A5_5A5A}
   };

   logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic        tdo, reg_wr, reg_rd;
   logic [7:0]  pwr_event = '0, pwr_ctl;
   logic [6:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [31:0] mem [128];
   int          errors = 0, checks = 0, wr_cnt = 0, rd_cnt = 0;

   always #4 tck = ~tck;

   dbg_tap_port #(.ID_CODE(IDV)) dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .pwr_event(pwr_event), .pwr_ctl(pwr_ctl), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_rd(reg_rd)
   );

   assign reg_rdata = mem[reg_addr];

   always @(posedge tck) begin
      if (reg_wr) begin
         mem[reg_addr] <= reg_wdata;
         wr_cnt = wr_cnt + 1;
      end
      if (reg_rd) rd_cnt = rd_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o, input logic [7:0] e = 8'h00);
      @(negedge tck);
      tms = m; tdi = d; pwr_event = e;
      #1 o = tdo;
   endtask

   task automatic finish_scan();
      @(posedge tck);
      #1 pwr_event = '0;
   endtask

   task automatic tap_reset();
      logic o;
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
      finish_scan();
   endtask

   task automatic ir_scan(input logic [IR_W-1:0] op, output logic [IR_W-1:0] cap);
      logic o;
      step(1'b1, 1'b0, o); step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
      for (int i = 0; i < IR_W; i++) begin
         step(i == IR_W - 1, op[i], o);
         cap[i] = o;
      end
      step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
      finish_scan();
   endtask

   task automatic dr_scan(input int n, input logic [31:0] din, input logic [7:0] ev,
                          output logic [31:0] dout);
      logic o;
      dout = '0;
      step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], o);
         dout[i] = o;
      end
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o, ev);
      finish_scan();
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [IR_W-1:0] cap;
      logic [31:0]     r;
      logic            o;
      int              w0, r0;
      for (int i = 0; i < 128; i++) mem[i] = '0;
      repeat (3) @(posedge tck);
      #1;
      chk(pwr_ctl == 8'h00, "R5 reset", {24'h0, pwr_ctl}, 32'h0);
      chk(!reg_wr && !reg_rd, "R9 reset strobes", {30'h0, reg_wr, reg_rd}, 32'h0);
      @(negedge tck); trst_n = 1'b1;
      step(1'b0, 1'b0, o);
      finish_scan();

      // R1: identification selected by reset
      dr_scan(32, 32'h0, 8'h00, r);
      chk(r == IDV, "R1 id after trst", r, IDV);

      // R2: capture pattern
      ir_scan(5'h1F, cap);
      chk(cap == 5'b00001, "R2 ir capture", {27'h0, cap}, 32'h1);

      // R3: bypass and unknown opcode
      dr_scan(8, 32'hA5, 8'h00, r);
      chk(r[7:0] == 8'h4A, "R3 bypass", r, 32'h4A);
      ir_scan(5'h03, cap);
      dr_scan(8, 32'h3C, 8'h00, r);
      chk(r[7:0] == 8'h78, "R3 unknown opcode", r, 32'h78);

      // R4
      ir_scan(5'h1E, cap);
      dr_scan(32, 32'hFFFF_FFFF, 8'h00, r);
      chk(r == IDV, "R4 idcode", r, IDV);

      // R5
      ir_scan(5'h08, cap);
      dr_scan(8, 32'h3C, 8'h00, r);
      chk(r[7:0] == 8'h00, "R5 capture reset value", r, 32'h0);
      chk(pwr_ctl == 8'h3C, "R5 update", {24'h0, pwr_ctl}, 32'h3C);
      dr_scan(8, 32'h81, 8'h00, r);
      chk(r[7:0] == 8'h3C, "R5 capture current", r, 32'h3C);
      chk(pwr_ctl == 8'h81, "R5 update 2", {24'h0, pwr_ctl}, 32'h81);

      // R6: sticky status, clear mask, same-cycle event
      step(1'b0, 1'b0, o, 8'h05);
      step(1'b0, 1'b0, o, 8'h00);
      finish_scan();
      ir_scan(5'h09, cap);
      dr_scan(8, 32'h01, 8'h00, r);
      chk(r[7:0] == 8'h05, "R6 status capture", r, 32'h05);
      dr_scan(8, 32'h00, 8'h00, r);
      chk(r[7:0] == 8'h04, "R6 masked clear", r, 32'h04);
      dr_scan(8, 32'h04, 8'h04, r);
      dr_scan(8, 32'h00, 8'h00, r);
      chk(r[7:0] == 8'h04, "R6 event wins over clear", r, 32'h04);
      dr_scan(8, 32'h04, 8'h00, r);
      dr_scan(8, 32'h00, 8'h00, r);
      chk(r[7:0] == 8'h00, "R6 clear alone", r, 32'h00);

      // R7 R8 R9: vector table
      foreach (VT[k]) begin
         w0 = wr_cnt; r0 = rd_cnt;
         ir_scan(5'h1C, cap);
         dr_scan(8, {24'h0, VT[k].a, VT[k].wr}, 8'h00, r);
         dr_scan(32, VT[k].wr ? VT[k].d : 32'h0, 8'h00, r);
         if (VT[k].wr) begin
            chk(wr_cnt == w0 + 1, "R9 one write strobe", 32'(wr_cnt - w0), 32'h1);
            chk(rd_cnt == r0, "R9 no read strobe", 32'(rd_cnt - r0), 32'h0);
         end else begin
            chk(r == VT[k].d, "R8 R7 read data", r, VT[k].d);
            chk(rd_cnt == r0 + 1, "R8 one read strobe", 32'(rd_cnt - r0), 32'h1);
            chk(wr_cnt == w0, "R8 no write on read", 32'(wr_cnt - w0), 32'h0);
         end
      end

      // R10: instruction reload drops a pending write
      w0 = wr_cnt;
      ir_scan(5'h1C, cap);
      dr_scan(8, {24'h0, 7'h05, 1'b1}, 8'h00, r);
      ir_scan(5'h1C, cap);
      dr_scan(8, {24'h0, 7'h7F, 1'b0}, 8'h00, r);
      dr_scan(32, 32'h0, 8'h00, r);
      chk(r == 32'h1234_5678, "R10 reload to address phase", r, 32'h1234_5678);
      chk(wr_cnt == w0, "R10 no stray write", 32'(wr_cnt - w0), 32'h0);

      // R10 R1: TAP reset through TMS
      ir_scan(5'h1C, cap);
      dr_scan(8, {24'h0, 7'h00, 1'b1}, 8'h00, r);
      tap_reset();
      dr_scan(32, 32'h0, 8'h00, r);
      chk(r == IDV, "R1 id after tms reset", r, IDV);
      ir_scan(5'h1C, cap);
      dr_scan(8, {24'h0, 7'h00, 1'b0}, 8'h00, r);
      dr_scan(32, 32'h0, 8'h00, r);
      chk(r == 32'hA5A5_5A5A, "R10 reset to address phase", r, 32'hA5A5_5A5A);
      chk(wr_cnt == w0, "R10 no write after reset", 32'(wr_cnt - w0), 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule